// File: doc/BRIEF.md
# Word-Program Flash Memory Controller

This block drives a small flash-like storage array held in a synthesizable register array. A host sets it up through a tiny register window. It selects a register with `host_sel` and writes with `host_we`. The read value appears on `host_rdata` one cycle after the select. Three of these registers carry an operation: the target word address, the 32-bit write data and a command word. The host writes the data first, then the address, then the command. The command starts a word program, a page erase or a whole-array erase.

The block keeps flash semantics. A program may only clear bits. A request that would raise any cleared bit is refused as a whole: no bit changes and an invalid-data status bit is raised. Erases are the only way back to all ones. Each operation stays busy for a fixed, parameterised number of cycles, and this stands in for cell timing. While an operation runs, read fetches to the affected pair of banks are stalled. Fetches to the other pair keep being served.

Failures are reported through three views of the status. The raw view always shows every event. The masked view is the raw view ANDed with an enable mask. A write-one-to-clear register removes bits from both views. A single interrupt line is the OR of the masked bits.

Top module: `flash_word_ctrl`

## Requirements
- R1: Register select codes are ADDR=0, DATA=1, CMD=2, RAW=3, MASK=4, MSTAT=5, CLEAR=6. ADDR and DATA read back the last value written. A CMD write with bit 0 set programs DATA into the word at ADDR.
- R2: A program whose data has no 1 where the stored word has a 0 leaves the word equal to the data, and raises no status bit.
- R3: A program whose data has a 1 where the stored word has a 0 changes no bit of the array and sets raw status bit 0 (invalid data).
- R4: CMD bit 1 sets every word of the PAGE_WORDS-aligned page that holds ADDR to all ones, and changes no other word. CMD bit 2 sets every word of the array to all ones.
- R5: A program or page erase whose ADDR is not below DEPTH changes no word and sets raw status bit 1 (operation error).
- R6: While an operation runs, CMD reads back bit 31 set together with the bit of the running command. This lasts exactly PROG_CYCLES, PAGE_CYCLES or MASS_CYCLES cycles of the read value. After that CMD reads zero, so the command bit clears itself.
- R7: A CMD write while an operation runs is ignored, and so is a CMD write without exactly one of bits 2:0 set.
- R8: A fetch to a pair of banks that is not locked returns `fetch_valid` with the stored word one cycle later. A running program or page erase locks the pair that holds its address, where the pair is the top address bit when there are four banks. A running mass erase locks every pair. A fetch to a locked pair raises `fetch_stall` and produces no `fetch_valid`.
- R9: RAW always shows the status bits. MSTAT shows RAW AND MASK. `irq` is the OR of the MSTAT bits.
- R10: Writing a 1 to a bit of CLEAR clears that bit in RAW and therefore also in MSTAT.
- R11: After reset CMD, RAW, MASK and MSTAT read zero, and `irq` and `fetch_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 3 | Register select |
| host_wdata | input | 32 | Register write value |
| host_rdata | output | 32 | Value of the register selected in the previous cycle |
| fetch_req | input | 1 | Read fetch request; held by the requester while stalled |
| fetch_addr | input | clog2(DEPTH) | Fetch word address |
| fetch_stall | output | 1 | Fetch targets a locked bank pair |
| fetch_valid | output | 1 | Fetch data valid |
| fetch_data | output | 32 | Fetched word |
| irq | output | 1 | OR of the masked status bits |

## Verification
On every cycle the assertions check three things. No command is accepted while busy. Each busy period lasts exactly the count for its operation. A stalled fetch never yields data, while an unstalled one always does. They also check that a status event is latched, that a clear takes effect, and that the interrupt matches the masked status. The array contents after each program, reject and erase can only be shown by the bench scenarios. This covers the full-word rejection that leaves every bit unchanged, page boundaries, out-of-range addresses that would otherwise alias, and commands dropped while busy. The bench sweeps every word of a small array through accepted and refused programs and reads the whole array back after each kind of operation.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_PAGE, OP_MASS} op_e;

  // register select codes
  localparam logic [2:0] SEL_ADDR  = 3'd0;
  localparam logic [2:0] SEL_DATA  = 3'd1;
  localparam logic [2:0] SEL_CMD   = 3'd2;
  localparam logic [2:0] SEL_RAW   = 3'd3;
  localparam logic [2:0] SEL_MASK  = 3'd4;
  localparam logic [2:0] SEL_MSTAT = 3'd5;
  localparam logic [2:0] SEL_CLEAR = 3'd6;

  // status bit positions
  localparam int ST_INV = 0;
  localparam int ST_ERR = 1;
  localparam int ST_W   = 2;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    a_addr,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // port A: fetch read
  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
  end

  // port B: controller read / write
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/flash_regs.sv
module flash_regs
  import flash_pkg::*;
#(
  parameter int HOST_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [2:0]         host_sel,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               busy,
  input  logic [2:0]         op_bits,
  input  logic               evt_inv,
  input  logic               evt_err,
  output logic               cmd_valid,
  output op_e                cmd_kind,
  output logic [HOST_AW-1:0] op_addr,
  output logic [31:0]        op_data,
  output logic               irq
);

  logic [HOST_AW-1:0] addr_q;
  logic [31:0]        data_q;
  logic [ST_W-1:0]    raw_q, mask_q, raw_n, mask_n, clr, setv;
  logic               irq_q;
  logic [31:0]        rdata_q, rd_mux;

  always_comb begin
    setv   = '0;
    setv[ST_INV] = evt_inv;
    setv[ST_ERR] = evt_err;
    clr    = (host_we && host_sel == SEL_CLEAR) ? host_wdata[ST_W-1:0] : '0;
    raw_n  = (raw_q & ~clr) | setv;   // a new event wins over a clear
    mask_n = (host_we && host_sel == SEL_MASK) ? host_wdata[ST_W-1:0] : mask_q;
  end

  // command decode: exactly one operation bit, controller idle
  assign cmd_valid = host_we && (host_sel == SEL_CMD) && $onehot(host_wdata[2:0]) && !busy;

  always_comb begin
    if (host_wdata[0])      cmd_kind = OP_PROG;
    else if (host_wdata[1]) cmd_kind = OP_PAGE;
    else if (host_wdata[2]) cmd_kind = OP_MASS;
    else                    cmd_kind = OP_IDLE;
  end

  always_comb begin
    case (host_sel)
      SEL_ADDR:  rd_mux = 32'(addr_q);
      SEL_DATA:  rd_mux = data_q;
      SEL_CMD:   rd_mux = {busy, 28'b0, op_bits};
      SEL_RAW:   rd_mux = 32'(raw_q);
      SEL_MASK:  rd_mux = 32'(mask_q);
      SEL_MSTAT,
      SEL_CLEAR: rd_mux = 32'(raw_q & mask_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      data_q  <= '0;
      raw_q   <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (host_we && host_sel == SEL_ADDR) addr_q <= host_wdata[HOST_AW-1:0];
      if (host_we && host_sel == SEL_DATA) data_q <= host_wdata;
      raw_q   <= raw_n;
      mask_q  <= mask_n;
      irq_q   <= |(raw_n & mask_n);
      rdata_q <= rd_mux;
    end
  end

  assign op_addr    = addr_q;
  assign op_data    = data_q;
  assign host_rdata = rdata_q;
  assign irq        = irq_q;

  // R3: an invalid-data event is latched into raw status
  a_r3_inv_latched: assert property (@(posedge clk) disable iff (rst)
    evt_inv |=> raw_q[ST_INV]);

  // R10: write-one-to-clear removes the bit unless a new event arrives
  a_r10_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_sel == SEL_CLEAR && host_wdata[ST_INV] && !evt_inv) |=> !raw_q[ST_INV]);

  // R9: interrupt line tracks the masked status
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|(raw_q & mask_q)));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int PAGE_WORDS  = 16,
  parameter int NUM_BANKS   = 4,
  parameter int HOST_AW     = 16,
  parameter int PROG_CYCLES = 8,
  parameter int PAGE_CYCLES = 32,
  parameter int MASS_CYCLES = 300,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  op_e                    cmd_kind,
  input  logic [HOST_AW-1:0]     op_addr,
  input  logic [31:0]            op_data,
  output logic                   busy,
  output logic [2:0]             op_bits,
  output logic                   evt_inv,
  output logic                   evt_err,
  output logic [NUM_BANKS/2-1:0] lock,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic [31:0]            mem_rdata
);

  localparam int IDX_W     = AW + 1;
  localparam int PG_W      = $clog2(PAGE_WORDS);
  localparam int NUM_PAIRS = NUM_BANKS / 2;
  localparam int PROG_LIM  = (PROG_CYCLES < 2) ? 2 : PROG_CYCLES;
  localparam int PAGE_LIM  = (PAGE_CYCLES < PAGE_WORDS) ? PAGE_WORDS : PAGE_CYCLES;
  localparam int MASS_LIM  = (MASS_CYCLES < DEPTH) ? DEPTH : MASS_CYCLES;
  localparam int MAX_A     = (PROG_LIM > PAGE_LIM) ? PROG_LIM : PAGE_LIM;
  localparam int MAX_LIM   = (MAX_A > MASS_LIM) ? MAX_A : MASS_LIM;
  localparam int CNT_W     = $clog2(MAX_LIM + 1);

  function automatic logic [CNT_W-1:0] lim_of(op_e k);
    case (k)
      OP_PROG: lim_of = CNT_W'(PROG_LIM);
      OP_PAGE: lim_of = CNT_W'(PAGE_LIM);
      OP_MASS: lim_of = CNT_W'(MASS_LIM);
      default: lim_of = '0;
    endcase
  endfunction

  logic               busy_q, bad_q, in_range, prog_ok;
  op_e                op_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   step_q;
  logic [HOST_AW-1:0] addr_q;
  logic [31:0]        data_q;

  assign in_range = (32'(op_addr) < 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      bad_q  <= 1'b0;
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
      step_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_valid && !busy_q) begin
      busy_q <= 1'b1;
      bad_q  <= (cmd_kind != OP_MASS) && !in_range;
      op_q   <= cmd_kind;
      cnt_q  <= lim_of(cmd_kind) - 1'b1;
      step_q <= '0;
      addr_q <= op_addr;
      data_q <= op_data;
    end else if (busy_q) begin
      if (step_q != '1) step_q <= step_q + 1'b1;
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        op_q   <= OP_IDLE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // array port: program reads in step 0 and writes in step 1; erases sweep words
  always_comb begin
    case (op_q)
      OP_PAGE: mem_addr = {addr_q[AW-1:PG_W], step_q[PG_W-1:0]};
      OP_MASS: mem_addr = step_q[AW-1:0];
      default: mem_addr = addr_q[AW-1:0];
    endcase
  end

  assign prog_ok   = ((~mem_rdata & data_q) == 32'd0);
  assign mem_wdata = (op_q == OP_PROG) ? data_q : '1;
  assign mem_we    = busy_q && !bad_q &&
                     ((op_q == OP_PROG && step_q == IDX_W'(1) && prog_ok) ||
                      (op_q == OP_PAGE && step_q < IDX_W'(PAGE_WORDS)) ||
                      (op_q == OP_MASS && step_q < IDX_W'(DEPTH)));
  assign evt_inv   = busy_q && !bad_q && op_q == OP_PROG && step_q == IDX_W'(1) && !prog_ok;
  assign evt_err   = busy_q && bad_q && step_q == '0;

  assign busy    = busy_q;
  assign op_bits = {op_q == OP_MASS, op_q == OP_PAGE, op_q == OP_PROG};

  generate
    if (NUM_PAIRS > 1) begin : g_pairs
      localparam int PAIR_W = $clog2(NUM_PAIRS);
      logic [PAIR_W-1:0] pair;
      assign pair = addr_q[AW-1 -: PAIR_W];
      always_comb begin
        lock = '0;
        if (busy_q && !bad_q) lock = (op_q == OP_MASS) ? '1 : (NUM_PAIRS'(1) << pair);
      end
    end else begin : g_single
      assign lock = busy_q && !bad_q;
    end
  endgenerate

  // independent busy-length tracking for the checker
  logic [CNT_W-1:0] chk_len;
  op_e              chk_op;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_len <= '0;
      chk_op  <= OP_IDLE;
    end else if (cmd_valid && !busy_q) begin
      chk_len <= '0;
      chk_op  <= cmd_kind;
    end else if (busy_q) begin
      chk_len <= chk_len + 1'b1;
    end
  end

  // R6: each operation stays busy for exactly its cycle count
  a_r6_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> chk_len == lim_of(chk_op));

  // R7: the register block never hands over a command while busy
  a_r7_idle_accept: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !busy_q);

endmodule

// File: rtl/flash_fetch.sv
module flash_fetch #(
  parameter int DEPTH     = 256,
  parameter int NUM_BANKS = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fetch_req,
  input  logic [AW-1:0]          fetch_addr,
  input  logic [NUM_BANKS/2-1:0] lock,
  output logic                   fetch_stall,
  output logic                   fetch_valid
);

  localparam int NUM_PAIRS = NUM_BANKS / 2;

  logic blocked, valid_q;

  generate
    if (NUM_PAIRS > 1) begin : g_pairs
      localparam int PAIR_W = $clog2(NUM_PAIRS);
      assign blocked = lock[fetch_addr[AW-1 -: PAIR_W]];
    end else begin : g_single
      assign blocked = lock[0];
    end
  endgenerate

  assign fetch_stall = fetch_req && blocked;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= fetch_req && !blocked;
  end

  assign fetch_valid = valid_q;

  // R8: a stalled fetch produces no data next cycle
  a_r8_stall_no_data: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |=> !fetch_valid);

  // R8: an unstalled fetch is always answered next cycle
  a_r8_served: assert property (@(posedge clk) disable iff (rst)
    (fetch_req && !fetch_stall) |=> fetch_valid);

endmodule

// File: rtl/flash_word_ctrl.sv
module flash_word_ctrl
  import flash_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int PAGE_WORDS  = 16,
  parameter int NUM_BANKS   = 4,
  parameter int HOST_AW     = 16,
  parameter int PROG_CYCLES = 8,
  parameter int PAGE_CYCLES = 32,
  parameter int MASS_CYCLES = 300
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_we,
  input  logic [2:0]               host_sel,
  input  logic [31:0]              host_wdata,
  output logic [31:0]              host_rdata,
  input  logic                     fetch_req,
  input  logic [$clog2(DEPTH)-1:0] fetch_addr,
  output logic                     fetch_stall,
  output logic                     fetch_valid,
  output logic [31:0]              fetch_data,
  output logic                     irq
);

  localparam int AW = $clog2(DEPTH);

  logic                   cmd_valid, busy, evt_inv, evt_err, mem_we;
  op_e                    cmd_kind;
  logic [HOST_AW-1:0]     op_addr;
  logic [31:0]            op_data, mem_wdata, mem_rdata;
  logic [2:0]             op_bits;
  logic [NUM_BANKS/2-1:0] lock;
  logic [AW-1:0]          mem_addr;

  flash_regs #(.HOST_AW(HOST_AW)) i_regs (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .op_bits(op_bits), .evt_inv(evt_inv), .evt_err(evt_err),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .op_addr(op_addr), .op_data(op_data),
    .irq(irq)
  );

  flash_seq #(
    .DEPTH(DEPTH), .PAGE_WORDS(PAGE_WORDS), .NUM_BANKS(NUM_BANKS), .HOST_AW(HOST_AW),
    .PROG_CYCLES(PROG_CYCLES), .PAGE_CYCLES(PAGE_CYCLES), .MASS_CYCLES(MASS_CYCLES)
  ) i_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .op_addr(op_addr), .op_data(op_data),
    .busy(busy), .op_bits(op_bits), .evt_inv(evt_inv), .evt_err(evt_err), .lock(lock),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  flash_fetch #(.DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS)) i_fetch (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .lock(lock),
    .fetch_stall(fetch_stall), .fetch_valid(fetch_valid)
  );

  flash_array #(.DEPTH(DEPTH), .WIDTH(32)) i_array (
    .clk(clk),
    .a_addr(fetch_addr), .a_rdata(fetch_data),
    .b_we(mem_we), .b_addr(mem_addr), .b_wdata(mem_wdata), .b_rdata(mem_rdata)
  );

endmodule

// File: tb/test_flash_word_ctrl.sv
module test_flash_word_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PAGE_WORDS = 4;
  localparam int PROG_N = 4;
  localparam int PAGE_N = 6;
  localparam int MASS_N = 18;

  localparam logic [2:0] S_ADDR = 3'd0, S_DATA = 3'd1, S_CMD = 3'd2, S_RAW = 3'd3,
                         S_MASK = 3'd4, S_MSTAT = 3'd5, S_CLEAR = 3'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_sel = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        fetch_req = 1'b0;
  logic [3:0]  fetch_addr = '0;
  logic        fetch_stall, fetch_valid, irq;
  logic [31:0] fetch_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_word_ctrl #(
    .DEPTH(DEPTH), .PAGE_WORDS(PAGE_WORDS), .NUM_BANKS(4), .HOST_AW(8),
    .PROG_CYCLES(PROG_N), .PAGE_CYCLES(PAGE_N), .MASS_CYCLES(MASS_N)
  ) i_flash_word_ctrl (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_stall(fetch_stall),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    host_sel = s;
    @(posedge clk); #1;
    v = host_rdata;
  endtask

  // after a CMD write: count cycles of busy read back (R6)
  task automatic measure(input logic [2:0] cmd, input int len, input string tag);
    int n = 0;
    logic [31:0] first = '0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      if (host_rdata[31]) begin
        if (n == 0) first = host_rdata;
        n++;
      end else break;
    end
    chk({"R6 busy length ", tag}, n, len);
    if (len > 0) chk({"R6 busy readback ", tag}, first, {1'b1, 28'b0, cmd});
    chk({"R6 self clear ", tag}, host_rdata, 32'd0);
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] d, input logic [2:0] cmd,
                        input int len, input string tag);
    wr(S_DATA, d);
    wr(S_ADDR, a);
    wr(S_CMD, {29'b0, cmd});
    measure(cmd, len, tag);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    host_sel = S_CMD;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      if (!host_rdata[31]) break;
    end
  endtask

  task automatic fetch(input logic [3:0] a, output logic st, output logic vl, output logic [31:0] dt);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    #1 st = fetch_stall;
    @(posedge clk); #1;
    vl = fetch_valid; dt = fetch_data;
    fetch_req = 1'b0;
  endtask

  task automatic check_word(input int a, input string tag);
    logic st, vl;
    logic [31:0] dt;
    fetch(4'(a), st, vl, dt);
    chk({tag, " fetch valid"}, {31'b0, vl}, 32'd1);
    chk({tag, " word"}, dt, model[a]);
  endtask

  task automatic verify_all(input string tag);
    for (int a = 0; a < DEPTH; a++) check_word(a, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, p1, p2, p3, d;
    logic st, vl;
    logic [31:0] dt;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11 reset state
    chk("R11 irq", {31'b0, irq}, 32'd0);
    chk("R11 fetch_valid", {31'b0, fetch_valid}, 32'd0);
    rd(S_CMD, v);   chk("R11 CMD", v, 32'd0);
    rd(S_RAW, v);   chk("R11 RAW", v, 32'd0);
    rd(S_MASK, v);  chk("R11 MASK", v, 32'd0);
    rd(S_MSTAT, v); chk("R11 MSTAT", v, 32'd0);

    // R4 mass erase initialises the array
    run_op(32'd0, 32'd0, 3'b100, MASS_N, "mass");
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    verify_all("R4 mass erase");

    // R1 register readback
    wr(S_DATA, 32'hA5C3_0F96); wr(S_ADDR, 32'd7);
    rd(S_DATA, v); chk("R1 DATA readback", v, 32'hA5C3_0F96);
    rd(S_ADDR, v); chk("R1 ADDR readback", v, 32'd7);

    // R1 R2 R3 R10 sweep over every word
    for (int a = 0; a < DEPTH; a++) begin
      p1 = ~((32'h1 << a) | (32'h8000_0000 >> a));
      run_op(32'(a), p1, 3'b001, PROG_N, "prog");
      model[a] = p1;
      rd(S_RAW, v); chk("R2 no status", v, 32'd0);
      check_word(a, "R1 R2 program");

      p2 = p1 | (32'h1 << a);
      run_op(32'(a), p2, 3'b001, PROG_N, "reject");
      rd(S_RAW, v); chk("R3 invalid bit", v, 32'd1);
      check_word(a, "R3 unchanged");
      wr(S_CLEAR, 32'd1);
      rd(S_RAW, v); chk("R10 cleared", v, 32'd0);

      p3 = p1 & ~(32'hF0 << a);
      run_op(32'(a), p3, 3'b001, PROG_N, "prog2");
      model[a] = p3;
      check_word(a, "R2 reprogram");
    end
    verify_all("R2 sweep");

    // R9 R5 R10 interrupt views
    run_op(32'd0, 32'hFFFF_FFFF, 3'b001, PROG_N, "reject0");
    rd(S_MSTAT, v); chk("R9 MSTAT masked off", v, 32'd0);
    chk("R9 irq masked off", {31'b0, irq}, 32'd0);
    wr(S_MASK, 32'd1);
    chk("R9 irq on", {31'b0, irq}, 32'd1);
    rd(S_MSTAT, v); chk("R9 MSTAT", v, 32'd1);
    run_op(32'd16, 32'd0, 3'b001, PROG_N, "prog out of range");
    rd(S_RAW, v); chk("R5 error bit", v, 32'd3);
    check_word(0, "R5 no alias");
    rd(S_MSTAT, v); chk("R9 MSTAT partial", v, 32'd1);
    wr(S_MASK, 32'd3);
    rd(S_MSTAT, v); chk("R9 MSTAT full", v, 32'd3);
    wr(S_CLEAR, 32'd1);
    rd(S_RAW, v); chk("R10 clear bit0", v, 32'd2);
    chk("R9 irq still", {31'b0, irq}, 32'd1);
    wr(S_CLEAR, 32'd2);
    rd(S_RAW, v); chk("R10 clear bit1", v, 32'd0);
    rd(S_MSTAT, v); chk("R10 MSTAT cleared", v, 32'd0);
    chk("R9 irq off", {31'b0, irq}, 32'd0);
    wr(S_MASK, 32'd0);

    // R5 page erase out of range
    run_op(32'd200, 32'd0, 3'b010, PAGE_N, "page out of range");
    rd(S_RAW, v); chk("R5 page error bit", v, 32'd2);
    verify_all("R5 page unchanged");
    wr(S_CLEAR, 32'd3);

    // R4 page erase of page holding word 9
    run_op(32'd9, 32'd0, 3'b010, PAGE_N, "page");
    for (int a = 8; a < 12; a++) model[a] = '1;
    rd(S_RAW, v); chk("R4 page no status", v, 32'd0);
    verify_all("R4 page erase");

    // R7 malformed command
    run_op(32'd1, 32'd0, 3'b011, 0, "two bits");
    verify_all("R7 malformed ignored");

    // R7 command while busy
    d = model[5] & 32'h0000_FFFF;
    wr(S_DATA, d); wr(S_ADDR, 32'd5);
    wr(S_CMD, 32'd1);
    wr(S_CMD, 32'd4);
    wait_idle();
    model[5] = d;
    verify_all("R7 busy ignored");

    // R8 stall on locked pair, service on other pair
    d = model[2] & 32'hFFFF_0000;
    wr(S_DATA, d); wr(S_ADDR, 32'd2);
    wr(S_CMD, 32'd1);
    fetch(4'd3, st, vl, dt);
    chk("R8 stall locked pair", {31'b0, st}, 32'd1);
    chk("R8 no valid when stalled", {31'b0, vl}, 32'd0);
    fetch(4'd12, st, vl, dt);
    chk("R8 other pair no stall", {31'b0, st}, 32'd0);
    chk("R8 other pair valid", {31'b0, vl}, 32'd1);
    chk("R8 other pair data", dt, model[12]);
    wait_idle();
    model[2] = d;
    check_word(2, "R8 after program");

    // R8 mass erase locks every pair
    wr(S_CMD, 32'd4);
    fetch(4'd12, st, vl, dt);
    chk("R8 mass stall high pair", {31'b0, st}, 32'd1);
    chk("R8 mass no valid", {31'b0, vl}, 32'd0);
    fetch(4'd0, st, vl, dt);
    chk("R8 mass stall low pair", {31'b0, st}, 32'd1);
    wait_idle();
    for (int a = 0; a < DEPTH; a++) model[a] = '1;
    verify_all("R4 final mass erase");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule